// File: doc/BRIEF.md
# Microstep Phase Current Sequencer

This block is the step indexer for a two-phase bipolar stepper motor. It keeps an electrical-angle position and moves it by one microstep each time the asynchronous step input rises. The direction input decides which way the position moves. From the position and the selected stepping mode, the block produces a signed target current code for each winding. Each code is a sign bit and a magnitude in percent of full scale, from 0 to 100. The analog current regulator and the power bridge that follow use these codes. A bridge-off output tells the bridge to float its outputs.

A 3-bit mode input selects one of these: full step, two kinds of half step, quarter step, eighth step, sixteenth step, or standby. Two mode codes both mean standby. Any change of mode restarts the sequence at the home position of the new mode. An active-low home input holds the sequence at home. An enable input turns the bridge on or off, but it does not stop the position from following the step input. Leaving standby, and coming out of system reset, starts a lockout of a parameterised number of clock cycles. During the lockout the block ignores the step input and keeps the bridge off.

An active-low monitor flag, shaped like an open-drain output, is pulled low while the position is at home. The flag is released in standby.

Top module: `stp_microstep_seq`

## Requirements
- R1: Mode codes 3'b000 and 3'b111 select standby. In standby, bridge_off is 1 even when enable_in is 1, and the position is held at home.
- R2: Each rising edge of step_in moves the position by one microstep of the active mode. The outputs show the new codes three clock rising edges after the step_in edge. dir_ccw=0 (clockwise) moves phase A ahead of phase B. dir_ccw=1 moves the position backwards.
- R3: While hold_home_n is 0, the position stays at home and step edges have no effect.
- R4: The home codes are A=+100, B=+0 in every stepping mode except full step (3'b001), where they are A=+100, B=-100.
- R5: Any change of mode_sel restarts the sequence at the home codes of the new mode.
- R6: The magnitude codes follow 100·sin of the angle, rounded. The sixteenth-step levels (mode 3'b110) are 0,10,20,29,38,47,56,63,71,77,83,88,92,96,98,100. Eighth step (3'b101) and quarter step (3'b100) use every second and every fourth of these levels. Half step type A (3'b010) uses 0/71/100. Half step type B (3'b011) uses 0/100. Full step uses 100 on both phases.
- R7: enable_in=0 sets bridge_off=1, and the position still follows step_in. enable_in=1 with hold_home_n=0 drives the bridge (bridge_off=0) with the home codes.
- R8: After the mode leaves standby, and after system reset, step edges are ignored for LOCK_CYCLES clock cycles. bridge_off stays 1 during that time.
- R9: home_od_n is 0 only while the position is at home and the mode is not standby. Otherwise it is 1 (released).
- R10: The position wraps every electrical cycle, which is 4·N microsteps in 1/N mode. Phase B lags phase A by a quarter cycle.
- R11: A sign bit (a_neg, b_neg; 1 = negative) is never 1 when its magnitude is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| step_in | input | 1 | Asynchronous step clock; each rising edge is one microstep |
| dir_ccw | input | 1 | 0 = clockwise, 1 = counter-clockwise |
| mode_sel | input | 3 | Stepping mode code (see R1, R6) |
| enable_in | input | 1 | 1 = bridge driven, 0 = bridge off |
| hold_home_n | input | 1 | 0 = hold the sequence at home |
| a_neg | output | 1 | Phase A sign, 1 = negative |
| a_mag | output | MAG_W | Phase A magnitude in percent |
| b_neg | output | 1 | Phase B sign, 1 = negative |
| b_mag | output | MAG_W | Phase B magnitude in percent |
| bridge_off | output | 1 | 1 = bridge outputs float |
| home_od_n | output | 1 | 0 = pulled low at home, 1 = released |

## Verification
The bench checks the wrap of the electrical cycle in both directions, including a 63-step run at sixteenth step. A counter without modulo arithmetic, or one that steps the wrong way, would show the wrong levels there. It also checks the two half-step variants at 45 degrees (71 against 100) and the full-step home offset. A design that mixed up the variants, or started full step at a B of zero, would give different codes at these points. Step edges are sent during the lockout after standby and while the home input is low. A design that did not block these edges would leave the home position. Standby is selected with the enable input high, to check that standby has priority over enable and that the monitor flag is released in standby.

// File: rtl/stp_pkg.sv
package stp_pkg;

   // Angle resolution is fixed by the finest mode: 16 microsteps per quarter cycle.
   localparam int POS_W = 6;
   localparam int QTR   = 1 << (POS_W - 2);

   typedef enum logic [2:0] {
      MD_IDLE_LO   = 3'b000,
      MD_FULL      = 3'b001,
      MD_HALF_A    = 3'b010,
      MD_HALF_B    = 3'b011,
      MD_QUARTER   = 3'b100,
      MD_EIGHTH    = 3'b101,
      MD_SIXTEENTH = 3'b110,
      MD_IDLE_HI   = 3'b111
   } step_mode_e;

   function automatic logic is_idle(input logic [2:0] m);
      return (m == MD_IDLE_LO) || (m == MD_IDLE_HI);
   endfunction

   // Angle advance per microstep, in sixteenth-of-quarter units.
   function automatic logic [POS_W-1:0] step_size(input logic [2:0] m);
      case (m)
         MD_FULL:              return POS_W'(16);
         MD_HALF_A, MD_HALF_B: return POS_W'(8);
         MD_QUARTER:           return POS_W'(4);
         MD_EIGHTH:            return POS_W'(2);
         MD_SIXTEENTH:         return POS_W'(1);
         default:              return '0;
      endcase
   endfunction

   // Rounded 100*sin(i*pi/32) for i = 0..16.
   function automatic logic [6:0] sine_pct(input logic [POS_W-2:0] i);
      case (i)
         5'd0:  return 7'd0;
         5'd1:  return 7'd10;
         5'd2:  return 7'd20;
         5'd3:  return 7'd29;
         5'd4:  return 7'd38;
         5'd5:  return 7'd47;
         5'd6:  return 7'd56;
         5'd7:  return 7'd63;
         5'd8:  return 7'd71;
         5'd9:  return 7'd77;
         5'd10: return 7'd83;
         5'd11: return 7'd88;
         5'd12: return 7'd92;
         5'd13: return 7'd96;
         5'd14: return 7'd98;
         default: return 7'd100;
      endcase
   endfunction

endpackage

// File: rtl/stp_step_sync.sv
module stp_step_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("stp_step_sync: STAGES must be at least 2");
   end

   // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value.
   logic [STAGES:0] chain;

   for (genvar g = 0; g <= STAGES; g++) begin : g_ff
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= async_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
      end
   end

   assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/stp_phase_index.sv
module stp_phase_index
   import stp_pkg::*;
#(
   parameter int LOCK_CYCLES = 800
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_pulse,
   input  logic             dir_ccw,
   input  logic             hold_home_n,
   input  logic [2:0]       mode_sel,
   output logic [POS_W-1:0] pos,
   output logic [2:0]       mode_q,
   output logic             idle,
   output logic             locked
);
   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("stp_phase_index: LOCK_CYCLES must be at least 1");
   end

   localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);

   logic [LOCK_W-1:0] lock_cnt;
   logic              mode_chg;
   logic              clr;
   logic [POS_W-1:0]  stride;

   assign idle     = is_idle(mode_q);
   assign locked   = (lock_cnt != '0);
   assign mode_chg = (mode_sel != mode_q);
   assign clr      = mode_chg | idle | locked | ~hold_home_n;
   assign stride   = step_size(mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MD_IDLE_LO;
         lock_cnt <= LOCK_W'(LOCK_CYCLES);
         pos      <= '0;
      end else begin
         mode_q <= mode_sel;
         if (idle)        lock_cnt <= LOCK_W'(LOCK_CYCLES);
         else if (locked) lock_cnt <= lock_cnt - 1'b1;
         if (clr)             pos <= '0;
         else if (step_pulse) pos <= dir_ccw ? (pos - stride) : (pos + stride);
      end
   end

   a_r3_hold_at_home: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_home_n |=> (pos == '0));
   a_r5_mode_restart: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> (pos == '0) && (mode_q == $past(mode_sel)));
   a_r8_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> (pos == '0));
   a_r2_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (step_pulse && !clr) |=> (pos != $past(pos)));

endmodule

// File: rtl/stp_current_map.sv
module stp_current_map
   import stp_pkg::*;
#(
   parameter int MAG_W = 7
) (
   input  logic [POS_W-1:0] pos,
   input  logic [2:0]       mode,
   output logic             a_neg,
   output logic [MAG_W-1:0] a_mag,
   output logic             b_neg,
   output logic [MAG_W-1:0] b_mag
);
   logic             full;
   logic             half_b;
   logic [1:0]       neg_v;
   logic [MAG_W-1:0] mag_v [2];

   assign full   = (mode == MD_FULL);
   assign half_b = (mode == MD_HALF_B);

   // Phase 0 (A) leads phase 1 (B) by one quarter cycle; full step sits half a step back.
   for (genvar ph = 0; ph < 2; ph++) begin : g_phase
      localparam int OFFS = (ph == 0) ? QTR : 0;
      logic [POS_W-1:0] ang;
      logic [1:0]       quad;
      logic [POS_W-3:0] off;
      logic [POS_W-2:0] idx;
      logic [6:0]       pct;

      assign ang  = pos + POS_W'(OFFS) - (full ? POS_W'(QTR / 2) : '0);
      assign quad = ang[POS_W-1:POS_W-2];
      assign off  = ang[POS_W-3:0];
      assign idx  = quad[0] ? ((POS_W-1)'(QTR) - {1'b0, off}) : {1'b0, off};

      always_comb begin
         if (full || (half_b && off == (POS_W-2)'(QTR / 2))) pct = 7'd100;
         else                                                pct = sine_pct(idx);
      end

      assign mag_v[ph] = MAG_W'(pct);
      assign neg_v[ph] = quad[1] & (pct != 7'd0);

      a_r11_no_neg_zero: assert property (@(pos) !(neg_v[ph] && mag_v[ph] == '0));
   end

   assign a_neg = neg_v[0];
   assign a_mag = mag_v[0];
   assign b_neg = neg_v[1];
   assign b_mag = mag_v[1];

endmodule

// File: rtl/stp_microstep_seq.sv
module stp_microstep_seq
   import stp_pkg::*;
#(
   parameter int LOCK_CYCLES = 800,
   parameter int SYNC_STAGES = 2,
   parameter int MAG_W       = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_in,
   input  logic             dir_ccw,
   input  logic [2:0]       mode_sel,
   input  logic             enable_in,
   input  logic             hold_home_n,
   output logic             a_neg,
   output logic [MAG_W-1:0] a_mag,
   output logic             b_neg,
   output logic [MAG_W-1:0] b_mag,
   output logic             bridge_off,
   output logic             home_od_n
);
   if (MAG_W < 7) begin : g_bad_mag
      $error("stp_microstep_seq: MAG_W must hold the value 100");
   end

   logic             step_pulse;
   logic [POS_W-1:0] pos;
   logic [2:0]       mode_q;
   logic             idle;
   logic             locked;

   stp_step_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (step_in),
      .rise_pulse (step_pulse)
   );

   stp_phase_index #(.LOCK_CYCLES(LOCK_CYCLES)) u_index (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_pulse  (step_pulse),
      .dir_ccw     (dir_ccw),
      .hold_home_n (hold_home_n),
      .mode_sel    (mode_sel),
      .pos         (pos),
      .mode_q      (mode_q),
      .idle        (idle),
      .locked      (locked)
   );

   stp_current_map #(.MAG_W(MAG_W)) u_map (
      .pos   (pos),
      .mode  (mode_q),
      .a_neg (a_neg),
      .a_mag (a_mag),
      .b_neg (b_neg),
      .b_mag (b_mag)
   );

   assign bridge_off = idle | locked | ~enable_in;
   assign home_od_n  = ~((pos == '0) & ~idle);

   a_r1_idle_bridge_off: assert property (@(posedge clk) disable iff (!rst_n)
      is_idle(mode_sel) |=> bridge_off);
   a_r9_idle_flag_free: assert property (@(posedge clk) disable iff (!rst_n)
      is_idle(mode_sel) |=> home_od_n);

endmodule

// File: tb/stp_microstep_seq_tb.sv
`timescale 1ns/1ps
module stp_microstep_seq_tb_top;

   localparam int LOCK = 40;
   localparam int NV   = 21;

   typedef struct packed {
      logic [2:0] mode;
      logic       dir;
      logic [5:0] n;
      logic       home;
      logic       an;
      logic [6:0] am;
      logic       bn;
      logic [6:0] bm;
   } vec_t;

   // mode, dir, steps, at-home, A sign, A mag, B sign, B mag
   localparam vec_t VECS [NV] = '{
      '{3'd1, 1'b0, 6'd0,  1'b1, 1'b0, 7'd100, 1'b1, 7'd100},
      '{3'd1, 1'b0, 6'd1,  1'b0, 1'b0, 7'd100, 1'b0, 7'd100},
      '{3'd1, 1'b0, 6'd1,  1'b0, 1'b1, 7'd100, 1'b0, 7'd100},
      '{3'd1, 1'b1, 6'd2,  1'b1, 1'b0, 7'd100, 1'b1, 7'd100},
      '{3'd1, 1'b1, 6'd1,  1'b0, 1'b1, 7'd100, 1'b1, 7'd100},
      '{3'd2, 1'b0, 6'd0,  1'b1, 1'b0, 7'd100, 1'b0, 7'd0},
      '{3'd2, 1'b0, 6'd1,  1'b0, 1'b0, 7'd71,  1'b0, 7'd71},
      '{3'd2, 1'b0, 6'd1,  1'b0, 1'b0, 7'd0,   1'b0, 7'd100},
      '{3'd2, 1'b1, 6'd3,  1'b0, 1'b0, 7'd71,  1'b1, 7'd71},
      '{3'd3, 1'b0, 6'd1,  1'b0, 1'b0, 7'd100, 1'b0, 7'd100},
      '{3'd3, 1'b0, 6'd2,  1'b0, 1'b1, 7'd100, 1'b0, 7'd100},
      '{3'd4, 1'b0, 6'd1,  1'b0, 1'b0, 7'd92,  1'b0, 7'd38},
      '{3'd4, 1'b0, 6'd1,  1'b0, 1'b0, 7'd71,  1'b0, 7'd71},
      '{3'd4, 1'b1, 6'd3,  1'b0, 1'b0, 7'd92,  1'b1, 7'd38},
      '{3'd5, 1'b0, 6'd3,  1'b0, 1'b0, 7'd83,  1'b0, 7'd56},
      '{3'd5, 1'b0, 6'd5,  1'b0, 1'b0, 7'd0,   1'b0, 7'd100},
      '{3'd6, 1'b0, 6'd1,  1'b0, 1'b0, 7'd100, 1'b0, 7'd10},
      '{3'd6, 1'b0, 6'd2,  1'b0, 1'b0, 7'd96,  1'b0, 7'd29},
      '{3'd6, 1'b1, 6'd4,  1'b0, 1'b0, 7'd100, 1'b1, 7'd10},
      '{3'd6, 1'b0, 6'd63, 1'b0, 1'b0, 7'd98,  1'b1, 7'd20},
      '{3'd6, 1'b0, 6'd2,  1'b1, 1'b0, 7'd100, 1'b0, 7'd0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_in = 1'b0;
   logic       dir_ccw = 1'b0;
   logic [2:0] mode_sel = 3'd1;
   logic       enable_in = 1'b1;
   logic       hold_home_n = 1'b1;
   logic       a_neg, b_neg, bridge_off, home_od_n;
   logic [6:0] a_mag, b_mag;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   stp_microstep_seq #(.LOCK_CYCLES(LOCK), .SYNC_STAGES(2), .MAG_W(7)) dut_i (
      .clk (clk), .rst_n (rst_n), .step_in (step_in), .dir_ccw (dir_ccw),
      .mode_sel (mode_sel), .enable_in (enable_in), .hold_home_n (hold_home_n),
      .a_neg (a_neg), .a_mag (a_mag), .b_neg (b_neg), .b_mag (b_mag),
      .bridge_off (bridge_off), .home_od_n (home_od_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] phases();
      return {16'd0, a_neg, a_mag, b_neg, b_mag};
   endfunction

   function automatic logic [31:0] code(input logic an, input logic [6:0] am,
                                        input logic bn, input logic [6:0] bm);
      return {16'd0, an, am, bn, bm};
   endfunction

   task automatic step_once();
      @(negedge clk) step_in = 1'b1;
      repeat (4) @(negedge clk);
      step_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk) mode_sel = m;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // Reset state: lockout active, home codes of full step, flag pulled low
      chk("R8 bridge off after reset", 32'(bridge_off), 32'd1);
      chk("R4 full-step home", phases(), code(1'b0, 7'd100, 1'b1, 7'd100));
      chk("R9 flag low at home", 32'(home_od_n), 32'd0);
      step_once();
      repeat (LOCK) @(negedge clk);
      chk("R8 step ignored in lockout", phases(), code(1'b0, 7'd100, 1'b1, 7'd100));
      chk("R7 bridge on after lockout", 32'(bridge_off), 32'd0);

      // Vector walk: R2 R4 R5 R6 R10 R11
      for (int v = 0; v < NV; v++) begin
         if (VECS[v].mode != mode_sel) set_mode(VECS[v].mode);
         dir_ccw = VECS[v].dir;
         for (int s = 0; s < int'(VECS[v].n); s++) step_once();
         chk($sformatf("R2 R5 R6 R10 R11 vector %0d codes", v), phases(),
             code(VECS[v].an, VECS[v].am, VECS[v].bn, VECS[v].bm));
         chk($sformatf("R9 vector %0d flag", v), 32'(home_od_n), 32'(!VECS[v].home));
      end

      // R7: enable low floats bridge but the position keeps following steps
      dir_ccw = 1'b0;
      @(negedge clk) enable_in = 1'b0;
      step_once();
      chk("R7 bridge off when disabled", 32'(bridge_off), 32'd1);
      chk("R7 position follows while disabled", phases(), code(1'b0, 7'd100, 1'b0, 7'd10));
      @(negedge clk) enable_in = 1'b1;
      @(negedge clk);
      chk("R7 bridge on when enabled", 32'(bridge_off), 32'd0);

      // R3: hold at home, steps have no effect
      @(negedge clk) hold_home_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R3 hold forces home", phases(), code(1'b0, 7'd100, 1'b0, 7'd0));
      chk("R7 home driven with enable high", 32'(bridge_off), 32'd0);
      step_once();
      chk("R3 step ignored during hold", phases(), code(1'b0, 7'd100, 1'b0, 7'd0));
      @(negedge clk) hold_home_n = 1'b1;
      step_once();

      // R1 / R9 / R8: standby codes, priority over enable, lockout on exit
      set_mode(3'b111);
      chk("R1 standby 111 bridge off", 32'(bridge_off), 32'd1);
      chk("R9 flag released in standby", 32'(home_od_n), 32'd1);
      chk("R1 standby holds home", phases(), code(1'b0, 7'd100, 1'b0, 7'd0));
      set_mode(3'b000);
      chk("R1 standby 000 bridge off", 32'(bridge_off), 32'd1);
      set_mode(3'b101);
      chk("R8 bridge off after standby exit", 32'(bridge_off), 32'd1);
      step_once();
      repeat (LOCK + 5) @(negedge clk);
      chk("R8 step ignored after standby exit", phases(), code(1'b0, 7'd100, 1'b0, 7'd0));
      chk("R8 bridge on after lockout", 32'(bridge_off), 32'd0);
      step_once();
      chk("R8 steps accepted after lockout", phases(), code(1'b0, 7'd98, 1'b0, 7'd20));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule